// File: doc/BRIEF.md
# Conversion Trigger Edge Selector

This block produces the start strobe for an analog-to-digital converter. A conversion can be requested from any one of several external trigger lines, chosen by an index, or from an internal request pulse. External lines are brought into the clock domain through two register stages. After that, an edge of the programmed polarity on the chosen line counts as one request.

Every accepted request produces a single-cycle start strobe for the converter. In the same cycle, the block begins an active-low pulse of fixed length on a dedicated output pin. The pin shows the real converter strobe whatever the source was. Its drive enable is off after reset and follows a software control bit after that.

Requests that arrive before the minimum spacing since the previous start are discarded. A discarded request sets a sticky error flag, which stays set until software clears it. With a 20 MHz clock, the defaults give a 100 ns pin pulse and a 5 µs minimum spacing.

Top module: `convTrigSel`

## Requirements
- R1: While reset is held and on the first cycle after it, `adcStart` is 0, `convPinN` is 1, `convPinOe` is 0 and `overrun` is 0.
- R2: With `risePol` = 1, a 0-to-1 change on `trigLines[srcSel]` produces exactly one `adcStart` pulse. With `risePol` = 0, a 1-to-0 change does so. The pulse is high in the third cycle after the change is first sampled, because of two synchronizer stages and the edge register.
- R3: Changes on lines other than `trigLines[srcSel]` produce no start. Changes of the opposite polarity on the selected line also produce no start.
- R4: `convReq` high at a clock edge produces `adcStart` high in the cycle that follows that edge.
- R5: `convPinN` goes low in the same cycle as every `adcStart`, whatever the source. It stays low for exactly PULSE_CYCLES (2) cycles and is never low at any other time.
- R6: `convPinOe` takes the value `outEnable` had at the previous clock edge.
- R7: A request is accepted only if at least MIN_GAP (100) cycles have passed since the previous accepted request. A request at MIN_GAP-1 cycles is discarded. A request at exactly MIN_GAP cycles is accepted.
- R8: A discarded request sets `overrun`. The flag stays set until `clrOverrun` is high at a clock edge. If a discard and a clear fall on the same edge, the flag stays set.
- R9: An external edge and an internal request that fall on the same accepting edge produce a single start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigLines | input | NUM_LINES | External trigger lines, asynchronous |
| srcSel | input | SEL_W | Index of the trigger line in use |
| risePol | input | 1 | 1 selects rising edges, 0 selects falling edges |
| convReq | input | 1 | Internal conversion request, one per high cycle |
| outEnable | input | 1 | Drive enable request for the output pin |
| clrOverrun | input | 1 | Clears the overrun flag |
| adcStart | output | 1 | Single-cycle start strobe to the converter |
| convPinN | output | 1 | Active-low convert pulse for the dedicated pin |
| convPinOe | output | 1 | Tri-state enable for the dedicated pin |
| overrun | output | 1 | Sticky flag for discarded requests |

## Verification
A change on an external line driven before clock edge k shows up on `adcStart` after edge k+2. An internal request sampled at edge k shows up after edge k. The pin goes low in that same cycle and recovers PULSE_CYCLES cycles later. `overrun` and `convPinOe` change one edge after their cause. The bench drives inputs on falling edges and samples every output on the following falling edges, using these fixed offsets. It never waits for an event, so a result that arrives one cycle early or late is reported as a miscompare. Spacing is checked by counting edges from the accepted start to the MIN_GAP-1 and MIN_GAP points.

// File: rtl/convTrigPkg.sv
package convTrigPkg;
  typedef struct packed {
    logic fire;   // request accepted this edge
    logic drop;   // request discarded, too close to previous start
  } ctlStrobes_t;
endpackage

// File: rtl/convTrigDatapath.sv
module convTrigDatapath
  import convTrigPkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int PULSE_CYCLES = 2,
  localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PCW   = $clog2(PULSE_CYCLES + 1)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] trigLines,
  input  logic [SEL_W-1:0]     srcSel,
  input  logic                 risePol,
  input  logic                 outEnable,
  input  ctlStrobes_t          strobes,
  output logic                 extEdge,
  output logic                 adcStart,
  output logic                 convPinN,
  output logic                 convPinOe
);
  logic [NUM_LINES-1:0] syncA, syncB, lastB;
  logic [PCW-1:0]       pulseCnt;
  logic                 selNow, selLast;

  // per-line two-stage synchronizer plus edge history
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b0;
        syncB[i] <= 1'b0;
        lastB[i] <= 1'b0;
      end else begin
        syncA[i] <= trigLines[i];
        syncB[i] <= syncA[i];
        lastB[i] <= syncB[i];
      end
    end
  end

  always_comb begin
    selNow  = syncB[srcSel];
    selLast = lastB[srcSel];
    extEdge = risePol ? (selNow & ~selLast) : (~selNow & selLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcStart  <= 1'b0;
      pulseCnt  <= '0;
      convPinOe <= 1'b0;
    end else begin
      adcStart  <= strobes.fire;
      convPinOe <= outEnable;
      if (strobes.fire)
        pulseCnt <= PCW'(PULSE_CYCLES);
      else if (pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign convPinN = (pulseCnt == '0);
endmodule

// File: rtl/convTrigControl.sv
module convTrigControl
  import convTrigPkg::*;
#(
  parameter int MIN_GAP = 100,
  localparam int GW = $clog2(MIN_GAP)
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        extEdge,
  input  logic        convReq,
  input  logic        clrOverrun,
  output ctlStrobes_t strobes,
  output logic        overrun
);
  logic [GW-1:0] gapCnt;
  logic          wantStart, ready;

  always_comb begin
    wantStart     = extEdge | convReq;
    ready         = (gapCnt == '0);
    strobes.fire  = wantStart & ready;
    strobes.drop  = wantStart & ~ready;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      if (strobes.fire)
        gapCnt <= GW'(MIN_GAP - 1);
      else if (!ready)
        gapCnt <= gapCnt - 1'b1;
      // a discard on the same edge as a clear keeps the flag set
      if (strobes.drop)
        overrun <= 1'b1;
      else if (clrOverrun)
        overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/convTrigSel.sv
module convTrigSel
  import convTrigPkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int PULSE_CYCLES = 2,
  parameter int MIN_GAP      = 100,
  localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] trigLines,
  input  logic [SEL_W-1:0]     srcSel,
  input  logic                 risePol,
  input  logic                 convReq,
  input  logic                 outEnable,
  input  logic                 clrOverrun,
  output logic                 adcStart,
  output logic                 convPinN,
  output logic                 convPinOe,
  output logic                 overrun
);
  ctlStrobes_t strobes;
  logic        extEdge;

  convTrigDatapath #(.NUM_LINES(NUM_LINES), .PULSE_CYCLES(PULSE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .trigLines(trigLines), .srcSel(srcSel),
    .risePol(risePol), .outEnable(outEnable), .strobes(strobes),
    .extEdge(extEdge), .adcStart(adcStart), .convPinN(convPinN),
    .convPinOe(convPinOe)
  );

  convTrigControl #(.MIN_GAP(MIN_GAP)) u_ctl (
    .clk(clk), .rstN(rstN), .extEdge(extEdge), .convReq(convReq),
    .clrOverrun(clrOverrun), .strobes(strobes), .overrun(overrun)
  );
endmodule

// File: rtl/convTrigChecker.sv
module convTrigChecker #(
  parameter int PULSE_CYCLES = 2,
  parameter int MIN_GAP      = 100
)(
  input logic clk,
  input logic rstN,
  input logic outEnable,
  input logic clrOverrun,
  input logic adcStart,
  input logic convPinN,
  input logic convPinOe,
  input logic overrun
);
  localparam int SW = $clog2(MIN_GAP + 1);
  localparam int LW = $clog2(PULSE_CYCLES + 1);
  logic [SW-1:0] sinceStart;
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= SW'(MIN_GAP);
      lowCnt     <= '0;
    end else begin
      if (adcStart) sinceStart <= SW'(1);
      else if (sinceStart < SW'(MIN_GAP)) sinceStart <= sinceStart + 1'b1;
      if (!convPinN && lowCnt < LW'(PULSE_CYCLES)) lowCnt <= lowCnt + 1'b1;
      else if (convPinN) lowCnt <= '0;
    end
  end

  assert_start_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> sinceStart >= SW'(MIN_GAP));
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);
  assert_pin_with_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> !convPinN);
  assert_pin_only_from_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convPinN) |-> adcStart);
  assert_pin_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    !convPinN |-> lowCnt < LW'(PULSE_CYCLES));
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrOverrun) |=> overrun);
  assert_oe_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convPinOe) |-> $past(outEnable));
endmodule

bind convTrigSel convTrigChecker #(.PULSE_CYCLES(PULSE_CYCLES), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rstN(rstN), .outEnable(outEnable), .clrOverrun(clrOverrun),
  .adcStart(adcStart), .convPinN(convPinN), .convPinOe(convPinOe),
  .overrun(overrun)
);

// File: tb/test_convTrigSel.sv
module test_convTrigSel;
  localparam int NL = 8;
  localparam int PW = 2;
  localparam int GAP = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0] trigLines = '0;
  logic [2:0] srcSel = '0;
  logic risePol = 1'b1;
  logic convReq = 1'b0, outEnable = 1'b0, clrOverrun = 1'b0;
  logic adcStart, convPinN, convPinOe, overrun;

  int nChecks = 0, nFails = 0, startCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  convTrigSel #(.NUM_LINES(NL), .PULSE_CYCLES(PW), .MIN_GAP(GAP)) i_convTrigSel (
    .clk(clk), .rstN(rstN), .trigLines(trigLines), .srcSel(srcSel),
    .risePol(risePol), .convReq(convReq), .outEnable(outEnable),
    .clrOverrun(clrOverrun), .adcStart(adcStart), .convPinN(convPinN),
    .convPinOe(convPinOe), .overrun(overrun)
  );

  always @(negedge clk) if (rstN && adcStart) startCount++;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    int base;
    // R1: reset values, during and just after reset
    ticks(3);
    check("R1 adcStart", adcStart, 0); check("R1 convPinN", convPinN, 1);
    check("R1 convPinOe", convPinOe, 0); check("R1 overrun", overrun, 0);
    rstN = 1'b1;
    ticks(1);
    check("R1 post adcStart", adcStart, 0); check("R1 post convPinN", convPinN, 1);
    check("R1 post convPinOe", convPinOe, 0);

    // R6: enable follows one edge later
    outEnable = 1'b1; ticks(1); check("R6 oe on", convPinOe, 1);
    outEnable = 1'b0; ticks(1); check("R6 oe off", convPinOe, 0);
    outEnable = 1'b1;

    // R2, R3, R5: sweep every line and both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int s = 0; s < NL; s++) begin
        risePol = pol[0];
        srcSel = 3'(s);
        ticks(1);
        trigLines = pol[0] ? '0 : '1;     // idle level, never an active edge
        ticks(GAP + 5);
        base = startCount;
        // R3: active edge on another line
        trigLines[(s + 1) % NL] = ~trigLines[(s + 1) % NL];
        ticks(6);
        check("R3 other line", startCount - base, 0);
        trigLines[(s + 1) % NL] = ~trigLines[(s + 1) % NL];
        ticks(6);
        check("R3 other line back", startCount - base, 0);
        // R2: active edge on selected line
        trigLines[s] = pol[0];
        ticks(2);
        check("R2 not early", adcStart, 0);
        ticks(1);
        check("R2 start", adcStart, 1);
        check("R5 pin low", convPinN, 0);
        ticks(1);
        check("R2 single", adcStart, 0);
        check("R5 pin still low", convPinN, 0);
        ticks(1);
        check("R5 pin released", convPinN, 1);
        ticks(GAP + 5);
        base = startCount;
        // R3: opposite edge on the selected line
        trigLines[s] = ~pol[0];
        ticks(6);
        check("R3 opposite edge", startCount - base, 0);
      end
    end

    // R4, R7, R8: internal requests and spacing
    ticks(GAP + 5);
    convReq = 1'b1; ticks(1); convReq = 1'b0;
    check("R4 start", adcStart, 1); check("R5 pin low int", convPinN, 0);
    ticks(GAP - 2);
    convReq = 1'b1; ticks(1); convReq = 1'b0;
    check("R7 early dropped", adcStart, 0);
    check("R8 overrun set", overrun, 1);
    convReq = 1'b1; ticks(1); convReq = 1'b0;
    check("R7 on time accepted", adcStart, 1);
    check("R8 overrun held", overrun, 1);
    clrOverrun = 1'b1; ticks(1); clrOverrun = 1'b0;
    check("R8 cleared", overrun, 0);
    convReq = 1'b1; clrOverrun = 1'b1; ticks(1);
    convReq = 1'b0; clrOverrun = 1'b0;
    check("R8 set beats clear", overrun, 1);
    check("R7 dropped no start", adcStart, 0);
    clrOverrun = 1'b1; ticks(1); clrOverrun = 1'b0;

    // R9: external edge and internal request on the same accepting edge
    ticks(GAP + 5);
    risePol = 1'b1; srcSel = 3'd2; trigLines = '0;
    ticks(6);
    base = startCount;
    trigLines[2] = 1'b1;
    ticks(2);
    convReq = 1'b1; ticks(1); convReq = 1'b0;
    check("R9 start", adcStart, 1);
    ticks(8);
    check("R9 single start", startCount - base, 1);
    check("R9 no overrun", overrun, 0);
    finish();
  end
endmodule